// File: doc/BRIEF.md
# Deadbeat Leg Reference Generator

This block sits in the control loop of a single-phase, three-level, neutral-clamped rectifier. On every sample strobe it computes, in closed form, the converter line voltage that would bring the source current onto its reference by the end of the following period. One period of computation delay is compensated by working one sample ahead. The line reference is then split into two equal and opposite leg references. A later stage uses these to pick switch states and to balance the neutral point.

Each strobe carries signed samples of the present source voltage, the source voltage predicted for the next instant, the source current, the newest current reference and the line voltage applied during the previous period. Four signed Q-format coefficients describe the filter: current retention `1 - R·T/L`, voltage gain `T/L`, series resistance `R`, and inductance over period `L/T`. An unsigned limit equal to half the dc-link voltage bounds the leg outputs. The block remembers the two previous current references and extrapolates the reference two instants ahead. It works in a four-stage pipeline and accepts a strobe on every clock.

Top module: `dbt_leg_ref`

## Requirements
- R1: The current reference two instants ahead is 6·r0 − 8·r1 + 3·r2. Here r0 is the reference on the current strobe and r1, r2 are the references of the two previous strobes. This equals applying the three-point extrapolation 3a − 3b + c twice.
- R2: The predicted current is floor((k_keep·is_now + k_gain·(vs_now − vab_prev)) / 2^F). It is clamped to the signed W-bit range and presented on `is_pred`. Coefficients are signed with F = 12 fraction bits.
- R3: The line reference is vs_next − floor((k_res·p + k_ind·(e − p)) / 2^F). Here p is the clamped predicted current and e the extrapolated reference. `leg_a` is floor(line reference / 2).
- R4: `leg_b` is always the exact two's-complement negative of `leg_a`.
- R5: `leg_a` is clamped to the range −v_lim … +v_lim. The clamp is applied before `leg_b` is formed.
- R6: For a strobe captured at clock edge n, `ref_vld` is high for exactly the cycle that follows edge n+3, and is low after edge n+2.
- R7: Reset clears the reference history. The first two strobes after reset produce no `ref_vld`; the third does.
- R8: Reset drives all outputs to zero. Between valid pulses, `leg_a`, `leg_b` and `is_pred` keep their last values.
- R9: Strobes on consecutive clocks produce valid results on consecutive clocks, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe; inputs are captured when it is high |
| vs_now | input | W | Source voltage at the present instant |
| vs_next | input | W | Source voltage expected at the next instant |
| is_now | input | W | Measured source current |
| iref_now | input | W | Newest current reference sample |
| vab_prev | input | W | Line voltage applied in the previous period |
| k_keep | input | CW | Current retention coefficient, Q(F) |
| k_gain | input | CW | Voltage-to-current gain coefficient, Q(F) |
| k_res | input | CW | Series resistance coefficient, Q(F) |
| k_ind | input | CW | Inductance over period coefficient, Q(F) |
| v_lim | input | W-1 | Leg reference magnitude limit (half dc link) |
| leg_a | output | W | Leg A reference voltage |
| leg_b | output | W | Leg B reference voltage |
| is_pred | output | W | Predicted source current for the next instant |
| ref_vld | output | 1 | One-cycle valid pulse for the outputs |

## Verification
The hardest conditions to reach from the ports are the ones where history and timing interact. These are warm-up after a reset in the middle of a run, and two strobes on adjacent clocks, where the second result must use a history already moved on by the first. The stimulus handles both directly. It issues a reset after the vector table, sends two strobes that must stay silent, and then sends a strobe pair with no gap, so the second result is computed from freshly shifted history. It also drives the current and voltage samples to the edges of their ranges, which pushes both the predicted current and the leg reference into their clamps in each direction.

// File: rtl/dbt_leg_ref.sv
module dbt_leg_ref #(
  parameter int W  = 16,
  parameter int CW = 18,
  parameter int F  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [W-1:0]  vs_now,
  input  logic signed [W-1:0]  vs_next,
  input  logic signed [W-1:0]  is_now,
  input  logic signed [W-1:0]  iref_now,
  input  logic signed [W-1:0]  vab_prev,
  input  logic signed [CW-1:0] k_keep,
  input  logic signed [CW-1:0] k_gain,
  input  logic signed [CW-1:0] k_res,
  input  logic signed [CW-1:0] k_ind,
  input  logic [W-2:0]         v_lim,
  output logic signed [W-1:0]  leg_a,
  output logic signed [W-1:0]  leg_b,
  output logic signed [W-1:0]  is_pred,
  output logic                 ref_vld
);
  localparam int EW = W + 5;
  localparam int SW = W + CW + 2;
  localparam int DW = EW + 1;
  localparam int LW = DW + CW + 1;
  localparam logic signed [SW-1:0] IMAX = SW'((2 ** (W - 1)) - 1);
  localparam logic signed [SW-1:0] IMIN = -IMAX - SW'(1);

  logic signed [W-1:0] h1, h2;
  logic [1:0] seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h1 <= '0;
      h2 <= '0;
      seen <= '0;
    end else if (smp_stb) begin
      h2 <= h1;
      h1 <= iref_now;
      if (seen != 2'd2) seen <= seen + 2'd1;
    end

  logic signed [W:0]    vdrop;
  logic signed [SW-1:0] acc1, isp_w;
  logic signed [W-1:0]  isp_c;
  logic signed [EW-1:0] r0e, r1e, r2e, ext;

  assign vdrop = vs_now - vab_prev;
  assign acc1  = k_keep * is_now + k_gain * vdrop;
  assign isp_w = acc1 >>> F;

  always_comb
    if (isp_w > IMAX)      isp_c = IMAX[W-1:0];
    else if (isp_w < IMIN) isp_c = IMIN[W-1:0];
    else                   isp_c = isp_w[W-1:0];

  assign r0e = iref_now;
  assign r1e = h1;
  assign r2e = h2;
  assign ext = (r0e <<< 2) + (r0e <<< 1) - (r1e <<< 3) + (r2e <<< 1) + r2e;

  logic                 s1_vld;
  logic signed [W-1:0]  s1_isp, s1_vsn;
  logic signed [EW-1:0] s1_ext;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_isp <= '0;
      s1_vsn <= '0;
      s1_ext <= '0;
    end else begin
      s1_vld <= smp_stb && (seen == 2'd2);
      s1_isp <= isp_c;
      s1_vsn <= vs_next;
      s1_ext <= ext;
    end

  logic signed [DW-1:0] diff;
  logic signed [LW-1:0] acc2;

  assign diff = s1_ext - s1_isp;
  assign acc2 = k_res * s1_isp + k_ind * diff;

  logic                 s2_vld;
  logic signed [LW-1:0] s2_acc;
  logic signed [W-1:0]  s2_isp, s2_vsn;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s2_vld <= 1'b0;
      s2_acc <= '0;
      s2_isp <= '0;
      s2_vsn <= '0;
    end else begin
      s2_vld <= s1_vld;
      s2_acc <= acc2;
      s2_isp <= s1_isp;
      s2_vsn <= s1_vsn;
    end

  logic signed [LW-1:0] vab_w, half_w, lim_w;
  logic signed [W-1:0]  leg_c;

  assign vab_w  = s2_vsn - (s2_acc >>> F);
  assign half_w = vab_w >>> 1;
  assign lim_w  = $signed({{(LW - W + 1){1'b0}}, v_lim});

  always_comb
    if (half_w > lim_w)       leg_c = lim_w[W-1:0];
    else if (half_w < -lim_w) leg_c = -lim_w[W-1:0];
    else                      leg_c = half_w[W-1:0];

  logic                s3_vld;
  logic signed [W-1:0] s3_leg, s3_isp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s3_vld <= 1'b0;
      s3_leg <= '0;
      s3_isp <= '0;
    end else begin
      s3_vld <= s2_vld;
      s3_leg <= leg_c;
      s3_isp <= s2_isp;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_vld <= 1'b0;
      leg_a   <= '0;
      leg_b   <= '0;
      is_pred <= '0;
    end else begin
      ref_vld <= s3_vld;
      if (s3_vld) begin
        leg_a   <= s3_leg;
        leg_b   <= -s3_leg;
        is_pred <= s3_isp;
      end
    end
endmodule

// File: rtl/dbt_leg_ref_chk.sv
module dbt_leg_ref_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_stb,
  input logic [W-2:0]        v_lim,
  input logic signed [W-1:0] leg_a,
  input logic signed [W-1:0] leg_b,
  input logic                ref_vld
);
  logic [1:0] nstb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) nstb <= '0;
    else if (smp_stb && nstb != 2'd3) nstb <= nstb + 2'd1;

  a_r4_antiphase: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld |-> (leg_b == -leg_a));

  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld |-> (leg_a <= $signed({1'b0, v_lim})) && (leg_a >= -$signed({1'b0, v_lim})));

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld |-> $past(smp_stb, 4));

  a_r7_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld |-> (nstb == 2'd3));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_vld |-> ($stable(leg_a) && $stable(leg_b)));
endmodule

bind dbt_leg_ref dbt_leg_ref_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .v_lim(v_lim),
  .leg_a(leg_a), .leg_b(leg_b), .ref_vld(ref_vld)
);

// File: tb/tb_dbt_leg_ref.sv
module tb_dbt_leg_ref;
  localparam longint KK = 3891, KG = 2048, KR = 410, KI = 8192, VL = 1000;
  localparam int N = 8;
  localparam int T_VS  [N] = '{1000, 1020, 1040, -500, 0, 800, -1200, 300};
  localparam int T_VSN [N] = '{1020, 1040, 1050, -520, 10, 790, -1190, 320};
  localparam int T_IS  [N] = '{100, 130, 150, -200, 0, 300, -50, 40};
  localparam int T_IR  [N] = '{120, 140, 160, -180, 20, 250, -100, 60};
  localparam int T_VAB [N] = '{900, 950, 980, -400, 0, 700, -1000, 200};

  logic clk = 0, rst_n = 0, smp_stb = 0;
  logic signed [15:0] vs_now = 0, vs_next = 0, is_now = 0, iref_now = 0, vab_prev = 0;
  logic signed [17:0] k_keep = 18'(KK), k_gain = 18'(KG), k_res = 18'(KR), k_ind = 18'(KI);
  logic [14:0] v_lim = 15'(VL);
  logic signed [15:0] leg_a, leg_b, is_pred;
  logic ref_vld;
  int checks = 0, errors = 0;
  longint hh1 = 0, hh2 = 0;

  always #2 clk = ~clk;

  dbt_leg_ref dut (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clampv(longint v, longint lo, longint hi);
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  task automatic model(input longint vs, vsn, is, ir, vab, output longint leg, output longint isp);
    longint e, acc;
    isp = clampv((KK * is + KG * (vs - vab)) >>> 12, -32768, 32767);
    e   = 6 * ir - 8 * hh1 + 3 * hh2;
    acc = KR * isp + KI * (e - isp);
    leg = clampv((vsn - (acc >>> 12)) >>> 1, -VL, VL);
    hh2 = hh1;
    hh1 = ir;
  endtask

  task automatic drive(int vs, vsn, is, ir, vab);
    vs_now = 16'(vs); vs_next = 16'(vsn); is_now = 16'(is);
    iref_now = 16'(ir); vab_prev = 16'(vab);
  endtask

  task automatic send(int vs, vsn, is, ir, vab, bit expv, string tag);
    longint eleg, eisp;
    model(vs, vsn, is, ir, vab, eleg, eisp);
    @(negedge clk); drive(vs, vsn, is, ir, vab); smp_stb = 1;
    @(posedge clk); @(negedge clk); smp_stb = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    if (expv) chk({tag, " R6 early valid"}, ref_vld, 0);
    @(posedge clk); @(negedge clk);
    chk({tag, " R6 R7 valid"}, ref_vld, expv);
    if (expv) begin
      chk({tag, " R1 R3 R5 leg_a"}, leg_a, eleg);
      chk({tag, " R4 leg_b"}, leg_b, -eleg);
      chk({tag, " R2 is_pred"}, is_pred, eisp);
    end
    @(posedge clk); @(negedge clk);
    chk({tag, " R6 single pulse"}, ref_vld, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", ref_vld, 0);
    chk("R8 reset leg_a", leg_a, 0);
    chk("R8 reset leg_b", leg_b, 0);
    chk("R8 reset is_pred", is_pred, 0);
    hh1 = 0; hh2 = 0;
    rst_n = 1;
  endtask

  initial begin
    longint la, pa, lb, pb;
    do_reset();
    send(500, 510, 50, 60, 400, 0, "warm1");
    send(510, 520, 60, 70, 420, 0, "warm2");
    for (int i = 0; i < N; i++)
      send(T_VS[i], T_VSN[i], T_IS[i], T_IR[i], T_VAB[i], 1, $sformatf("vec%0d", i));
    chk("R8 hold leg_a", leg_a, la_last());
    send(0, 30000, 0, 0, 0, 1, "satpos R5");
    send(0, -30000, 0, 0, 0, 1, "satneg R5");
    send(32000, 0, 32000, 0, -32000, 1, "isp_hi R2");
    send(-32000, 0, -32000, 0, 32000, 1, "isp_lo R2");
    do_reset();
    send(100, 100, 10, 900, 50, 0, "rwarm1 R7");
    chk("R7 R8 hold after warm-up strobe", leg_a, 0);
    send(100, 100, 10, -900, 50, 0, "rwarm2 R7");
    model(200, 210, 20, 30, 150, la, pa);
    model(-300, -310, -40, -20, -250, lb, pb);
    @(negedge clk); drive(200, 210, 20, 30, 150); smp_stb = 1;
    @(negedge clk); drive(-300, -310, -40, -20, -250);
    @(negedge clk); smp_stb = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 first valid", ref_vld, 1);
    chk("R9 first leg_a", leg_a, la);
    chk("R9 first is_pred", is_pred, pa);
    @(posedge clk); @(negedge clk);
    chk("R9 second valid", ref_vld, 1);
    chk("R9 second leg_a", leg_a, lb);
    chk("R9 second is_pred", is_pred, pb);
    @(posedge clk); @(negedge clk);
    chk("R9 pulse end", ref_vld, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic longint la_last();
    longint e, acc, isp;
    isp = clampv((KK * T_IS[N-1] + KG * (T_VS[N-1] - T_VAB[N-1])) >>> 12, -32768, 32767);
    e   = 6 * T_IR[N-1] - 8 * T_IR[N-2] + 3 * T_IR[N-3];
    acc = KR * isp + KI * (e - isp);
    return clampv((T_VSN[N-1] - (acc >>> 12)) >>> 1, -VL, VL);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule